// File: doc/BRIEF.md
# I/O Card Select and Control Logic

This block is the control half of a peripheral card that sits on a select-code I/O bus. Two address-match lines and an I/O-cycle qualifier together say that the card is being addressed. Only then are the bus commands applied: the two data strobes, the two skip tests, and the set and clear commands for the control and flag flip-flops. The timing phases, the interrupt-system lines, the bus-wide clear and the software reset bit are seen whether or not the card is addressed.

Three sources can reset the card: power-on or preset, the bus-wide clear, and a software reset bit. The software bit counts only after the driver has armed the card. Any of the three starts a timer, and the timer holds a card reset pulse for a fixed time of 5 µs. The pulse length is derived from the clock frequency. The card holds a control flip-flop, a flag buffer and flag, an interrupt request, a service request and an interrupt lockout. It takes part in a daisy-chained interrupt priority through an active-low priority input and an active-low priority output.

Top module: `bus_card_ctrl`

## Requirements
- R1: The card is selected exactly when `sel_upper`, `sel_lower` and `io_cycle` are all 1. `data_wr_stb` equals `out_stb` and `data_rd_stb` equals `in_stb` while the card is selected; both are 0 otherwise.
- R2: When the card is not selected, `ctl_set`, `ctl_clr`, `flg_set`, `flg_clr`, `skip_set_q` and `skip_clr_q` have no effect on any state or output.
- R3: `prio_in_n`, `int_en`, `flag_phase`, `int_phase`, `int_ack`, `phase_t3`, `bus_clear` and `soft_rst_bit` act whether or not the card is selected.
- R4: A reset request comes from `pwr_preset`, from `bus_clear`, or from `soft_rst_bit` while the soft-reset arm flip-flop is set. A selected `ctl_set` sets the arm; a card reset clears it.
- R5: At the first clock edge with a reset request, `card_rst` rises. It stays at 1 for RST_CYCLES = CLK_KHZ*PULSE_NS/1e6 cycles after the last request: 625 cycles at 125 MHz and 5000 ns. A new request restarts the count.
- R6: While `card_rst` is 1, each edge clears the control flip-flop, flag buffer, flag, `irq_out` and `srq_out`, and sets the lockout. `rst_n` low forces the same state.
- R7: A selected `ctl_set` sets the control flip-flop and releases the lockout. A selected `ctl_clr` clears the control flip-flop, and clear wins when both are asserted.
- R8: A selected `flg_set` sets the flag buffer and a selected `flg_clr` clears it; clear wins. On each edge with `flag_phase` at 1, the flag loads the buffer.
- R9: On an edge with `int_phase` at 1, `irq_out` loads (control AND flag AND `int_en` AND `prio_in_n` AND NOT lockout), and `srq_out` loads the flag.
- R10: An edge with `int_ack`, `phase_t3` and `irq_out` all at 1 clears `irq_out` and the flag buffer. Acknowledge wins over `int_phase`.
- R11: `prio_out_n` is 0 when `prio_in_n` is 0 or `irq_out` is 1, and is 1 otherwise.
- R12: `skip_out` is 1 only while the card is selected and either `skip_set_q` is 1 with the flag set, or `skip_clr_q` is 1 with the flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| sel_upper | input | 1 | Upper select-code match |
| sel_lower | input | 1 | Lower select-code match |
| io_cycle | input | 1 | I/O cycle qualifier |
| out_stb | input | 1 | Output data strobe |
| in_stb | input | 1 | Input data strobe |
| skip_set_q | input | 1 | Skip if flag set |
| skip_clr_q | input | 1 | Skip if flag clear |
| ctl_set | input | 1 | Set control |
| ctl_clr | input | 1 | Clear control |
| flg_set | input | 1 | Set flag buffer |
| flg_clr | input | 1 | Clear flag buffer |
| prio_in_n | input | 1 | Priority in, active low |
| int_en | input | 1 | System interrupt enable |
| flag_phase | input | 1 | Flag load phase |
| int_phase | input | 1 | Interrupt request phase |
| int_ack | input | 1 | Interrupt acknowledge |
| phase_t3 | input | 1 | Acknowledge timing phase |
| bus_clear | input | 1 | Bus-wide clear |
| soft_rst_bit | input | 1 | Software reset bit |
| pwr_preset | input | 1 | Power-on or preset |
| data_wr_stb | output | 1 | Gated output strobe |
| data_rd_stb | output | 1 | Gated input strobe |
| skip_out | output | 1 | Skip response |
| card_rst | output | 1 | Stretched card reset |
| irq_out | output | 1 | Interrupt request |
| srq_out | output | 1 | Service request |
| prio_out_n | output | 1 | Priority out, active low |

## Verification
A wrong control or flag flip-flop stays hidden until the next interrupt phase or skip test. The bench therefore reads the flag through a selected skip test one cycle after each update. It reads the control state through `irq_out` on the following interrupt phase. A stuck lockout or a missing acknowledge shows on `irq_out` and `prio_out_n` within one edge. A pulse timer that is off by one changes the measured `card_rst` width, so the bench counts the width to the exact cycle.

// File: rtl/bus_card_pkg.sv
package bus_card_pkg;
  typedef struct packed {
    logic ctl_set;
    logic ctl_clr;
    logic flg_set;
    logic flg_clr;
    logic skip_set;
    logic skip_clr;
    logic wr;
    logic rd;
  } bus_cmd_t;

  // Pulse length in clock cycles for a given clock (kHz) and duration (ns).
  function automatic int unsigned pulse_cycles(input int unsigned khz, input int unsigned ns);
    longint unsigned prod;
    prod = longint'(khz) * longint'(ns);
    return int'(prod / 64'd1_000_000);
  endfunction

  function automatic logic skip_eval(input logic sel, input logic q_set,
                                     input logic q_clr, input logic flag);
    return sel & ((q_set & flag) | (q_clr & ~flag));
  endfunction
endpackage

// File: rtl/bcc_select.sv
module bcc_select
  import bus_card_pkg::*;
(
  input  logic     sel_upper,
  input  logic     sel_lower,
  input  logic     io_cycle,
  input  bus_cmd_t cmd_in,
  output logic     selected,
  output bus_cmd_t cmd_out
);
  assign selected = sel_upper & sel_lower & io_cycle;
  assign cmd_out  = selected ? cmd_in : '0;
endmodule

// File: rtl/bcc_reset_timer.sv
module bcc_reset_timer #(
  parameter int unsigned RST_CYCLES = 625
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic pulse
);
  localparam int unsigned CW = $clog2(RST_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (req)       cnt <= CW'(RST_CYCLES);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign pulse = (cnt != '0);
endmodule

// File: rtl/bcc_flags.sv
module bcc_flags
  import bus_card_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     card_rst,
  input  bus_cmd_t cmd,
  input  logic     int_en,
  input  logic     prio_in_n,
  input  logic     flag_phase,
  input  logic     int_phase,
  input  logic     int_ack,
  input  logic     phase_t3,
  output logic     ctl_q,
  output logic     flag_q,
  output logic     lockout_q,
  output logic     arm_q,
  output logic     irq_q,
  output logic     srq_q,
  output logic     ack_hit
);
  logic fbuf_q;

  assign ack_hit = int_ack & phase_t3 & irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= 1'b0; fbuf_q <= 1'b0; flag_q <= 1'b0;
      lockout_q <= 1'b1; arm_q <= 1'b0; irq_q <= 1'b0; srq_q <= 1'b0;
    end else if (card_rst) begin
      ctl_q <= 1'b0; fbuf_q <= 1'b0; flag_q <= 1'b0;
      lockout_q <= 1'b1; arm_q <= 1'b0; irq_q <= 1'b0; srq_q <= 1'b0;
    end else begin
      if (cmd.ctl_clr)      ctl_q <= 1'b0;
      else if (cmd.ctl_set) ctl_q <= 1'b1;
      if (cmd.ctl_set) begin
        lockout_q <= 1'b0;
        arm_q     <= 1'b1;
      end
      if (ack_hit || cmd.flg_clr) fbuf_q <= 1'b0;
      else if (cmd.flg_set)       fbuf_q <= 1'b1;
      if (flag_phase) flag_q <= fbuf_q;
      if (ack_hit)        irq_q <= 1'b0;
      else if (int_phase) irq_q <= ctl_q & flag_q & int_en & prio_in_n & ~lockout_q;
      if (int_phase) srq_q <= flag_q;
    end
  end
endmodule

// File: rtl/bus_card_ctrl.sv
module bus_card_ctrl
  import bus_card_pkg::*;
#(
  parameter int unsigned CLK_KHZ  = 125000,
  parameter int unsigned PULSE_NS = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_upper,
  input  logic sel_lower,
  input  logic io_cycle,
  input  logic out_stb,
  input  logic in_stb,
  input  logic skip_set_q,
  input  logic skip_clr_q,
  input  logic ctl_set,
  input  logic ctl_clr,
  input  logic flg_set,
  input  logic flg_clr,
  input  logic prio_in_n,
  input  logic int_en,
  input  logic flag_phase,
  input  logic int_phase,
  input  logic int_ack,
  input  logic phase_t3,
  input  logic bus_clear,
  input  logic soft_rst_bit,
  input  logic pwr_preset,
  output logic data_wr_stb,
  output logic data_rd_stb,
  output logic skip_out,
  output logic card_rst,
  output logic irq_out,
  output logic srq_out,
  output logic prio_out_n
);
  localparam int unsigned RST_CYCLES = pulse_cycles(CLK_KHZ, PULSE_NS);

  bus_cmd_t raw_cmd, gated_cmd;
  logic selected, rst_req, ctl_q, flag_q, lockout_q, arm_q, ack_hit;

  assign raw_cmd = '{ctl_set: ctl_set, ctl_clr: ctl_clr, flg_set: flg_set,
                     flg_clr: flg_clr, skip_set: skip_set_q, skip_clr: skip_clr_q,
                     wr: out_stb, rd: in_stb};

  bcc_select u_sel (
    .sel_upper(sel_upper), .sel_lower(sel_lower), .io_cycle(io_cycle),
    .cmd_in(raw_cmd), .selected(selected), .cmd_out(gated_cmd)
  );

  assign rst_req = pwr_preset | bus_clear | (soft_rst_bit & arm_q);

  bcc_reset_timer #(.RST_CYCLES(RST_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .req(rst_req), .pulse(card_rst)
  );

  bcc_flags u_flags (
    .clk(clk), .rst_n(rst_n), .card_rst(card_rst), .cmd(gated_cmd),
    .int_en(int_en), .prio_in_n(prio_in_n), .flag_phase(flag_phase),
    .int_phase(int_phase), .int_ack(int_ack), .phase_t3(phase_t3),
    .ctl_q(ctl_q), .flag_q(flag_q), .lockout_q(lockout_q), .arm_q(arm_q),
    .irq_q(irq_out), .srq_q(srq_out), .ack_hit(ack_hit)
  );

  assign data_wr_stb = gated_cmd.wr;
  assign data_rd_stb = gated_cmd.rd;
  assign skip_out    = skip_eval(selected, gated_cmd.skip_set, gated_cmd.skip_clr, flag_q);
  assign prio_out_n  = ~(~prio_in_n | irq_out);
endmodule

// File: rtl/bus_card_ctrl_chk.sv
module bus_card_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic sel_upper,
  input logic sel_lower,
  input logic io_cycle,
  input logic data_wr_stb,
  input logic skip_out,
  input logic card_rst,
  input logic rst_req,
  input logic irq_out,
  input logic srq_out,
  input logic int_phase,
  input logic int_en,
  input logic prio_in_n,
  input logic prio_out_n,
  input logic ack_hit,
  input logic lockout_q
);
  assert_strobe_needs_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr_stb |-> (sel_upper && sel_lower && io_cycle));

  assert_skip_needs_select_R12: assert property (@(posedge clk) disable iff (!rst_n)
    skip_out |-> (sel_upper && sel_lower && io_cycle));

  assert_pulse_from_request_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_rst) |-> $past(rst_req));

  assert_reset_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |=> (!irq_out && !srq_out && lockout_q));

  assert_irq_conditions_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(int_phase && int_en && prio_in_n));

  assert_ack_drops_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !card_rst) |=> !irq_out);

  assert_prio_chain_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!prio_in_n || irq_out) |-> !prio_out_n);
endmodule

bind bus_card_ctrl bus_card_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel_upper(sel_upper), .sel_lower(sel_lower),
  .io_cycle(io_cycle), .data_wr_stb(data_wr_stb), .skip_out(skip_out),
  .card_rst(card_rst), .rst_req(rst_req), .irq_out(irq_out), .srq_out(srq_out),
  .int_phase(int_phase), .int_en(int_en), .prio_in_n(prio_in_n),
  .prio_out_n(prio_out_n), .ack_hit(ack_hit), .lockout_q(lockout_q)
);

// File: tb/bus_card_ctrl_bench.sv
`timescale 1ns/1ps
module bus_card_ctrl_bench;
  localparam int NCYC = 125000 * 5000 / 1000000;  // 625
  localparam int B_RST = 6, B_IRQ = 5, B_SRQ = 4, B_SKP = 3, B_PRI = 2, B_WR = 1, B_RD = 0;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, sel_upper, sel_lower, io_cycle, out_stb, in_stb, skip_set_q, skip_clr_q;
  logic ctl_set, ctl_clr, flg_set, flg_clr, prio_in_n, int_en, flag_phase, int_phase;
  logic int_ack, phase_t3, bus_clear, soft_rst_bit, pwr_preset;
  logic data_wr_stb, data_rd_stb, skip_out, card_rst, irq_out, srq_out, prio_out_n;

  bus_card_ctrl u_bus_card_ctrl (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { string tag; logic [6:0] mask; logic [6:0] val; } exp_t;
  exp_t sb[$];

  wire [6:0] obs = {card_rst, irq_out, srq_out, skip_out, prio_out_n, data_wr_stb, data_rd_stb};

  // Monitor: pops every pending expectation at the falling edge.
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if ((obs & e.mask) !== (e.val & e.mask)) begin
        errors++;
        $display("FAIL %s: actual %b expected %b (mask %b)", e.tag, obs & e.mask, e.val & e.mask, e.mask);
      end
    end
  end

  task automatic expb(input string tag, input int bitn, input logic v);
    exp_t e;
    e.tag = tag; e.mask = 7'b1 << bitn; e.val = {7{v}} & (7'b1 << bitn);
    sb.push_back(e);
  endtask

  task automatic flush(); @(negedge clk); #1; endtask
  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk_val(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic pulse_width(output int w);
    w = 0;
    while (card_rst === 1'b1 && w < 5000) begin
      w++;
      @(negedge clk); #1;
    end
  endtask

  task automatic sel(input logic v); sel_upper = v; sel_lower = v; io_cycle = v; endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int w;
    rst_n = 0; sel(0); out_stb = 0; in_stb = 0; skip_set_q = 0; skip_clr_q = 0;
    ctl_set = 0; ctl_clr = 0; flg_set = 0; flg_clr = 0; prio_in_n = 1; int_en = 0;
    flag_phase = 0; int_phase = 0; int_ack = 0; phase_t3 = 0; bus_clear = 0;
    soft_rst_bit = 0; pwr_preset = 0;
    repeat (3) tick();
    rst_n = 1; tick();
    expb("R6 reset irq", B_IRQ, 0); expb("R6 reset srq", B_SRQ, 0);
    expb("R6 reset card_rst", B_RST, 0); expb("R11 idle prio", B_PRI, 1);
    flush();

    // R4/R5: power-on request, pulse width
    pwr_preset = 1; tick(); pwr_preset = 0;
    flush();
    pulse_width(w); chk_val("R5 preset pulse width", w, NCYC);

    // R4/R5: bus clear, retrigger restarts count
    bus_clear = 1; tick(); bus_clear = 0;
    repeat (100) tick();
    expb("R5 still high mid pulse", B_RST, 1); flush();
    bus_clear = 1; tick(); bus_clear = 0;
    flush();
    pulse_width(w); chk_val("R5 retrigger width", w, NCYC);

    // R4: soft bit ignored while unarmed
    soft_rst_bit = 1; repeat (3) tick(); soft_rst_bit = 0;
    expb("R4 soft unarmed ignored", B_RST, 0); flush();

    // R1: select decode
    out_stb = 1; in_stb = 1; sel(1); #1;
    expb("R1 wr when selected", B_WR, 1); expb("R1 rd when selected", B_RD, 1); flush();
    io_cycle = 0; #1;
    expb("R1 wr no io_cycle", B_WR, 0); expb("R1 rd no io_cycle", B_RD, 0); flush();
    sel_upper = 1; sel_lower = 0; io_cycle = 1; #1;
    expb("R1 wr partial match", B_WR, 0); flush();
    out_stb = 0; in_stb = 0; sel(0);

    // R2: commands ignored when unselected (R3 phases still act)
    ctl_set = 1; flg_set = 1; tick(); ctl_set = 0; flg_set = 0;
    int_en = 1; flag_phase = 1; tick(); flag_phase = 0;
    int_phase = 1; tick(); int_phase = 0;
    skip_set_q = 1; #1;
    expb("R2 irq unaffected", B_IRQ, 0); expb("R2 skip unselected", B_SKP, 0); flush();
    skip_set_q = 0; sel(1); skip_clr_q = 1; #1;
    expb("R12 skip on clear flag", B_SKP, 1); flush();
    skip_clr_q = 0;

    // R7/R8/R9: full interrupt path while selected
    ctl_set = 1; tick(); ctl_set = 0;
    flg_set = 1; tick(); flg_set = 0;
    flag_phase = 1; tick(); flag_phase = 0;
    skip_set_q = 1; #1;
    expb("R8 flag loaded", B_SKP, 1); flush(); skip_set_q = 0;
    sel(0);
    int_phase = 1; tick(); int_phase = 0;
    expb("R9 irq raised", B_IRQ, 1); expb("R9 srq follows flag", B_SRQ, 1);
    expb("R11 prio out low on irq", B_PRI, 0); flush();

    // R9/R3: higher priority blocks request
    prio_in_n = 0; int_phase = 1; tick(); int_phase = 0;
    expb("R9 blocked by priority", B_IRQ, 0); expb("R11 prio passes low", B_PRI, 0); flush();
    prio_in_n = 1; #1;
    expb("R11 prio high when idle", B_PRI, 1); flush();
    int_phase = 1; tick(); int_phase = 0;
    expb("R9 irq re-raised", B_IRQ, 1); flush();

    // R10: acknowledge needs t3
    int_ack = 1; tick();
    expb("R10 ack without t3", B_IRQ, 1); flush();
    phase_t3 = 1; int_phase = 1; tick(); int_ack = 0; phase_t3 = 0; int_phase = 0;
    expb("R10 ack clears irq", B_IRQ, 0); flush();
    flag_phase = 1; tick(); flag_phase = 0;
    sel(1); skip_clr_q = 1; #1;
    expb("R10 flag buffer cleared", B_SKP, 1); flush(); skip_clr_q = 0;

    // R8: clear wins over set
    flg_set = 1; flg_clr = 1; tick(); flg_set = 0; flg_clr = 0;
    flag_phase = 1; tick(); flag_phase = 0;
    skip_clr_q = 1; #1;
    expb("R8 flag clear wins", B_SKP, 1); flush(); skip_clr_q = 0;

    // R7: clear control, and clear wins
    flg_set = 1; tick(); flg_set = 0;
    flag_phase = 1; tick(); flag_phase = 0;
    ctl_clr = 1; tick(); ctl_clr = 0;
    int_phase = 1; tick(); int_phase = 0;
    expb("R7 ctl cleared no irq", B_IRQ, 0); expb("R9 srq with flag", B_SRQ, 1); flush();
    ctl_set = 1; ctl_clr = 1; tick(); ctl_set = 0; ctl_clr = 0;
    int_phase = 1; tick(); int_phase = 0;
    expb("R7 ctl clear wins", B_IRQ, 0); flush();
    ctl_set = 1; tick(); ctl_set = 0;
    int_phase = 1; tick(); int_phase = 0;
    expb("R7 ctl set irq", B_IRQ, 1); flush();
    sel(0);

    // R4/R6: armed soft reset, then state cleared and arm dropped
    soft_rst_bit = 1; tick(); soft_rst_bit = 0;
    expb("R4 soft armed reset", B_RST, 1); flush();
    pulse_width(w); chk_val("R5 soft pulse width", w, NCYC);
    sel(1); skip_clr_q = 1; #1;
    expb("R6 irq cleared", B_IRQ, 0); expb("R6 srq cleared", B_SRQ, 0);
    expb("R6 flag cleared", B_SKP, 1); expb("R6 prio released", B_PRI, 1); flush();
    skip_clr_q = 0; sel(0);
    soft_rst_bit = 1; tick(); soft_rst_bit = 0;
    expb("R4 arm cleared by reset", B_RST, 0); flush();

    // R6 lockout: flag and control set via unlocking STC then new reset relocks
    sel(1); ctl_set = 1; flg_set = 1; tick(); ctl_set = 0; flg_set = 0; sel(0);
    pwr_preset = 1; tick(); pwr_preset = 0;
    flush(); pulse_width(w);
    int_phase = 1; tick(); int_phase = 0;
    expb("R6 lockout after reset", B_IRQ, 0); flush();

    summary();
  end
endmodule